// File: doc/BRIEF.md
# Power-On Delayed Reset Generator

This block drives the reset input of a microcontroller core while the board supplies come up slowly. It watches a power-good indication and counts on the free-running oscillator clock. Once power-good has been seen high, the core reset stays asserted for a programmable settling delay, expressed in prescaled ticks. It then stays asserted for a further fixed tail of oscillator cycles. The default tail is 24 cycles, which is two machine cycles of twelve oscillator periods each.

A loss of power-good re-arms the block immediately. The whole count starts again from zero when power returns, just as a discharged timing capacitor would restart. An external watchdog request is merged by OR into the same registered output, so either source resets the core. The settling delay is taken from an input bus while the block's own reset is held. It stays fixed from then on, so the delay can be sized for supplies that need half a second or more to settle.

Top module: `por_delay_reset`

## Requirements
- R1: While `rst` is high, and on the cycle after any clock edge that samples `rst` high, `core_rst_o` is 1.
- R2: `pwr_good_i` passes through a two-flop synchronizer that `rst` clears. A change on `pwr_good_i` sampled at clock edge k reaches the internal power-good at edge k+1 and affects `core_rst_o` from edge k+2.
- R3: Let edge 0 be the first clock edge at which the synchronized power-good is 1. Counting from that edge, `core_rst_o` stays 1 for exactly D*PRESCALE+TAIL edges and falls at edge D*PRESCALE+TAIL. D is the latched delay.
- R4: With a latched delay of 0, only the tail applies, and reset is held for exactly TAIL cycles after synchronized power-good.
- R5: `delay_ticks_i` is captured on every edge where `rst` is high. Changes to it while `rst` is low have no effect on any later release timing.
- R6: Any cycle with synchronized power-good low clears all progress and forces `core_rst_o` to 1 on the next edge. After power-good returns, the full D*PRESCALE+TAIL count restarts from zero.
- R7: `wdog_req_i` high at an edge makes `core_rst_o` 1 after that edge, whatever the power-on state. When the request ends and power-on timing is complete, reset drops on the following edge.
- R8: `core_rst_o` comes straight from a flip-flop. Once released, it stays 0 while power-good stays high and no watchdog request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset of this block |
| pwr_good_i | input | 1 | Digitized power-good level, asynchronous to clk |
| delay_ticks_i | input | DLY_W | Settling delay in prescaled ticks, captured during reset |
| wdog_req_i | input | 1 | Watchdog reset request, merged by OR |
| core_rst_o | output | 1 | Registered reset to the core, active high |

## Verification
Several properties are checked on every cycle: reset and watchdog requests force the output on the next edge, a low synchronized power-good forces it, the two-edge synchronizer latency holds, the latched delay stays constant outside reset, and a release happens only after the tail has completed. The exact release cycle for several delays, the full restart after a power-good glitch during settling or during the tail, and the fact that a delay change outside reset is ignored can only be shown by the bench. Its per-cycle reference model follows these scenarios through.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TAIL   = 2'd2,
    PH_DONE   = 2'd3
  } por_phase_e;
endpackage

// File: rtl/por_sync2.sv
module por_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/por_tick_gen.sv
module por_tick_gen #(
  parameter int PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] cnt;

      assign tick = en && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/por_hold_seq.sv
module por_hold_seq
  import por_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int TAIL  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pg_s,
  input  logic [DLY_W-1:0] dly,
  input  logic             tick,
  output logic             settle_en,
  output logic             tail_done,
  output por_phase_e       phase
);
  localparam int TAIL_W = $clog2(TAIL + 1);
  localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL);

  logic [DLY_W-1:0]  settle_cnt;
  logic [TAIL_W-1:0] tail_cnt;
  logic              settle_done;
  logic              clr;

  assign clr         = rst || !pg_s;
  assign settle_done = (settle_cnt == dly);
  assign tail_done   = (tail_cnt == TAIL_END);
  assign settle_en   = pg_s && !settle_done;

  always_ff @(posedge clk) begin
    if (clr)                    settle_cnt <= '0;
    else if (settle_en && tick) settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr)                             tail_cnt <= '0;
    else if (settle_done && !tail_done)  tail_cnt <= tail_cnt + 1'b1;
  end

  always_comb begin
    if (!pg_s)             phase = PH_IDLE;
    else if (!settle_done) phase = PH_SETTLE;
    else if (!tail_done)   phase = PH_TAIL;
    else                   phase = PH_DONE;
  end
endmodule

// File: rtl/por_delay_reset.sv
module por_delay_reset
  import por_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int PRESCALE = 1000,
  parameter int TAIL     = 24,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good_i,
  input  logic [DLY_W-1:0] delay_ticks_i,
  input  logic             wdog_req_i,
  output logic             core_rst_o
);
  logic             pg_s;
  logic [DLY_W-1:0] dly_lat;
  logic             settle_en;
  logic             tick;
  logic             tail_done;
  por_phase_e       phase;
  logic             core_rst_q;

  por_sync2 #(.STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_good_i),
    .q   (pg_s)
  );

  always_ff @(posedge clk) begin
    if (rst) dly_lat <= delay_ticks_i;
  end

  por_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (!pg_s),
    .en   (settle_en),
    .tick (tick)
  );

  por_hold_seq #(.DLY_W(DLY_W), .TAIL(TAIL)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pg_s      (pg_s),
    .dly       (dly_lat),
    .tick      (tick),
    .settle_en (settle_en),
    .tail_done (tail_done),
    .phase     (phase)
  );

  always_ff @(posedge clk) begin
    core_rst_q <= rst || wdog_req_i || (phase != PH_DONE);
  end

  assign core_rst_o = core_rst_q;
endmodule

// File: rtl/por_delay_reset_chk.sv
module por_delay_reset_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_good_i,
  input logic             wdog_req_i,
  input logic             core_rst_o,
  input logic             pg_s,
  input logic [DLY_W-1:0] dly_lat,
  input logic             tail_done
);
  AST_RST_FORCES: assert property (@(posedge clk) rst |=> core_rst_o); // R1

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (pg_s == $past(pwr_good_i, 2))); // R2

  AST_RELEASE_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> $past(tail_done)); // R3

  AST_DELAY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dly_lat)); // R5

  AST_PG_LOW_FORCES: assert property (@(posedge clk) disable iff (rst)
    !pg_s |=> core_rst_o); // R6

  AST_WDOG_FORCES: assert property (@(posedge clk) disable iff (rst)
    wdog_req_i |=> core_rst_o); // R7

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (!core_rst_o && pg_s && !wdog_req_i) |=> !core_rst_o); // R8
endmodule

bind por_delay_reset por_delay_reset_chk #(.DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_good_i (pwr_good_i),
  .wdog_req_i (wdog_req_i),
  .core_rst_o (core_rst_o),
  .pg_s       (pg_s),
  .dly_lat    (dly_lat),
  .tail_done  (tail_done)
);

// File: tb/tb_por_delay_reset.sv
`timescale 1ns/1ps
module tb_por_delay_reset;
  localparam int DLY_W    = 8;
  localparam int PRESCALE = 4;
  localparam int TAIL     = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pwr_good = 1'b0;
  logic [DLY_W-1:0] delay_ticks = 8'd3;
  logic             wdog = 1'b0;
  logic             core_rst;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // behavioural reference state
  bit     m_s1 = 1'b0, m_s2 = 1'b0;
  int     m_d = 0;
  int     m_cnt = 0;
  bit     exp_rst = 1'b1;
  bit     started = 1'b0;

  always #2.5 clk = ~clk;

  por_delay_reset #(.DLY_W(DLY_W), .PRESCALE(PRESCALE), .TAIL(TAIL)) dut (
    .clk           (clk),
    .rst           (rst),
    .pwr_good_i    (pwr_good),
    .delay_ticks_i (delay_ticks),
    .wdog_req_i    (wdog),
    .core_rst_o    (core_rst)
  );

  always @(posedge clk) begin
    int lim;
    lim = m_d * PRESCALE + TAIL;
    exp_rst = rst || wdog || !m_s2 || (m_cnt < lim);
    if (rst || !m_s2) m_cnt = 0;
    else if (m_cnt < lim) m_cnt = m_cnt + 1;
    if (rst) begin
      m_d  = int'(delay_ticks);
      m_s1 = 1'b0;
      m_s2 = 1'b0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pwr_good;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (core_rst !== exp_rst) begin
        failures++;
        $display("FAIL %s cycle compare: core_rst_o=%b expected=%b at %0t",
                 cur_req, core_rst, exp_rst, $time);
      end
    end
  end

  task automatic chk(input bit expv, input string tag);
    checks++;
    if (core_rst !== expv) begin
      failures++;
      $display("FAIL %s point check: core_rst_o=%b expected=%b", tag, core_rst, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog timeout: core_rst_o=%b expected=end_of_run", core_rst);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    cyc(4);
    chk(1'b1, "R1");
    rst = 1'b0;
    cur_req = "R2";
    cyc(10);
    chk(1'b1, "R2");

    // R3: delay 3 ticks of 4 cycles plus 24 tail, released 36 edges after pg_s
    cur_req = "R3";
    pwr_good = 1'b1;
    cyc(20);
    chk(1'b1, "R3");
    cyc(25);
    chk(1'b0, "R3");

    // R5: new delay value outside reset must be ignored
    cur_req = "R5";
    delay_ticks = 8'd50;
    cyc(3);
    // R6: one-cycle glitch during run restarts the count
    cur_req = "R6";
    pwr_good = 1'b0;
    cyc(1);
    pwr_good = 1'b1;
    cyc(30);
    chk(1'b1, "R6");
    cur_req = "R5";
    cyc(15);
    chk(1'b0, "R5");

    // R7: watchdog request
    cur_req = "R7";
    wdog = 1'b1;
    cyc(3);
    chk(1'b1, "R7");
    wdog = 1'b0;
    cyc(2);
    chk(1'b0, "R7");
    // R8: stays released
    cur_req = "R8";
    cyc(40);
    chk(1'b0, "R8");

    // R6: drop in mid-settling, count restarts from zero
    cur_req = "R6";
    pwr_good = 1'b0;
    cyc(3);
    pwr_good = 1'b1;
    cyc(10);
    pwr_good = 1'b0;
    cyc(3);
    pwr_good = 1'b1;
    cyc(30);
    chk(1'b1, "R6");
    cyc(15);
    chk(1'b0, "R6");
    // drop during tail
    pwr_good = 1'b0;
    cyc(2);
    pwr_good = 1'b1;
    cyc(25);
    pwr_good = 1'b0;
    cyc(1);
    pwr_good = 1'b1;
    cyc(35);
    chk(1'b1, "R6");
    cyc(10);
    chk(1'b0, "R6");

    // R4: zero delay, tail only
    cur_req = "R4";
    delay_ticks = 8'd0;
    rst = 1'b1;
    cyc(3);
    chk(1'b1, "R1");
    rst = 1'b0;
    cyc(22);
    chk(1'b1, "R4");
    cyc(6);
    chk(1'b0, "R4");

    // R3: longest delay 255 ticks
    cur_req = "R3";
    delay_ticks = 8'd255;
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    delay_ticks = 8'd1;
    cyc(1040);
    chk(1'b1, "R3");
    cyc(10);
    chk(1'b0, "R3");
    // watchdog while power-good low
    cur_req = "R7";
    pwr_good = 1'b0;
    wdog = 1'b1;
    cyc(4);
    chk(1'b1, "R7");
    wdog = 1'b0;
    pwr_good = 1'b1;
    cyc(10);
    finish_run();
  end
endmodule